// File: doc/BRIEF.md
# Power-Ratio Channel Gain Equalizer

This block sits behind a bank of interleaved sub-converters whose outputs have already had their DC error removed. Samples arrive one at a time as a single round-robin stream. Each valid sample is tagged with the next channel index in turn. The block scales every sample by a gain factor that belongs to its channel. The factors make every channel's gain match the gain of channel 0, which is the reference.

The block estimates gain from signal power. Over a block of N samples per channel, it accumulates the sum of squared samples for every channel. Because all channels collect the same number of samples, the ratio of two sums equals the ratio of the two mean powers. A single sequential engine then works through the channels other than the reference, one after another. For each one it divides the reference sum by the channel's sum in fixed point and takes an integer square root. The new factors reach the multipliers together, in a single cycle, once the last channel is finished.

The factors are exposed on a port so that a timing-correction stage further down the chain, or a test, can observe them.

Top module: `pwr_gain_equalizer`

## Requirements
- R1: A sample on channel 0 leaves the block unchanged, one cycle after it enters, and gain field 0 always reads 0x4000.
- R2: After reset the first valid sample belongs to channel 0. Each later valid sample takes the next channel index, wrapping from NCH-1 back to 0. Cycles without valid do not advance the index.
- R3: For every valid input x on channel c, out_valid is high on the following cycle. That cycle's out_sample is ((x*g[c] + 2^13) >>> 14), saturated to the signed DW-bit range, where g[c] is the factor applied when the sample was taken. A cycle without valid is followed by out_valid low.
- R4: Gain factors are unsigned fixed point with 2 integer bits and 14 fractional bits. All factors reset to 0x4000, which is 1.0. Channel c's factor sits at gain_flat[16c+15:16c].
- R5: A block is N valid samples per channel, which is NCH*N valid samples in total. With block sums S0 and Sc of squared samples, the new factor for channel c is floor(sqrt(floor(S0*2^28/Sc))).
- R6: When S0 >= 16*Sc, the new factor for channel c is 0xFFFF.
- R7: When Sc is zero, channel c keeps its previous factor.
- R8: All factors computed from one block change in the same clock cycle, some time after that block's last sample. Factors do not change at any other time.
- R9: Every block starts its sums from zero, so a factor depends only on the samples of the block it was computed from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | DW | Signed, offset-free interleaved sample |
| out_valid | output | 1 | Output sample qualifier |
| out_sample | output | DW | Signed equalized sample |
| gain_flat | output | NCH*16 | Applied gain factors, one 16-bit field per channel |

## Verification
The assertions assume that the stream never halts partway through a way the channel counter cannot follow. They also assume that a block's factors are committed before the next block ends; with the default sizes this holds, because the engine needs about 160 cycles and a block is 256 valid samples long. The stimulus respects both assumptions. Each block is driven completely and is followed by a long idle gap before the factors are read. Random idle cycles inside a block only stretch it out in time. Amplitudes are chosen per channel so that the blocks reach the directed corners: a silent channel, a channel whose power is more than 16 times below the reference, and full-scale inputs that drive the output into saturation.

// File: rtl/pge_pkg.sv
package pge_pkg;

    // Gain factor format: unsigned, 2 integer bits, 14 fractional bits
    localparam int GAIN_W    = 16;
    localparam int GAIN_FRAC = 14;
    localparam int GAIN_INT  = GAIN_W - GAIN_FRAC;
    localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1) << GAIN_FRAC;
    localparam logic [GAIN_W-1:0] GAIN_MAX = '1;

    // Power ratio is carried with 2*GAIN_FRAC fractional bits, so its root has GAIN_FRAC
    localparam int QUO_W     = 2 * GAIN_W;
    // Largest ratio representable before the root overflows the gain format
    localparam int RATIO_LOG = 2 * GAIN_INT;

    typedef enum logic [1:0] {
        RR_IDLE,
        RR_DIV,
        RR_ROOT,
        RR_DONE
    } rr_state_e;

    typedef enum logic [1:0] {
        GB_IDLE,
        GB_LAUNCH,
        GB_WAIT,
        GB_COMMIT
    } gb_state_e;

    function automatic int ch_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pge_power_acc.sv
module pge_power_acc import pge_pkg::*; #(
    parameter int NCH  = 4,
    parameter int DW   = 12,
    parameter int NLOG = 6,
    parameter int CW   = 2,
    parameter int SW   = 30
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid_i,
    input  logic signed [DW-1:0]     in_sample_i,
    output logic [CW-1:0]            ch_o,
    output logic                     blk_end_o,
    output logic [NCH-1:0][SW-1:0]   fin_o
);

    logic [CW-1:0]          ch_q;
    logic [NLOG-1:0]        cnt_q;
    logic signed [2*DW-1:0] sq_s;
    logic [SW-1:0]          sq_u;
    logic                   last_ch;
    logic                   fresh;

    assign sq_s    = in_sample_i * in_sample_i;
    assign sq_u    = SW'(unsigned'(sq_s));
    assign last_ch = (ch_q == CW'(NCH - 1));
    assign fresh   = (cnt_q == '0);

    assign ch_o      = ch_q;
    assign blk_end_o = in_valid_i && last_ch && (&cnt_q);

    // Round-robin channel index and per-channel sample count
    always_ff @(posedge clk) begin
        if (rst) begin
            ch_q  <= '0;
            cnt_q <= '0;
        end else if (in_valid_i) begin
            if (last_ch) begin
                ch_q  <= '0;
                cnt_q <= cnt_q + 1'b1;
            end else begin
                ch_q <= ch_q + 1'b1;
            end
        end
    end

    // One sum-of-squares accumulator per channel, restarted at every block
    for (genvar c = 0; c < NCH; c++) begin : g_acc
        logic [SW-1:0] acc_q;
        logic          hit;
        logic [SW-1:0] base;

        assign hit  = in_valid_i && (ch_q == CW'(c));
        assign base = fresh ? '0 : acc_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q <= '0;
            end else if (hit) begin
                acc_q <= base + sq_u;
            end
        end

        // Final block sum, valid in the cycle blk_end_o is high
        assign fin_o[c] = hit ? (base + sq_u) : acc_q;
    end

endmodule

// File: rtl/pge_ratio_root.sv
module pge_ratio_root import pge_pkg::*; #(
    parameter int SW = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [SW-1:0]     num_i,
    input  logic [SW-1:0]     den_i,
    output logic              done_o,
    output logic              keep_o,
    output logic [GAIN_W-1:0] root_o
);

    localparam int RW = SW + RATIO_LOG + 1;
    localparam int TW = $clog2(QUO_W);

    rr_state_e          state_q;
    logic [RW-1:0]      rem_q;
    logic [RW-1:0]      dsh_q;
    logic [QUO_W-1:0]   quo_q;
    logic [GAIN_W-1:0]  root_q;
    logic [TW-1:0]      step_q;
    logic               keep_q;
    logic [GAIN_W-1:0]  trial;
    logic [QUO_W-1:0]   trial_sq;
    logic               too_big;

    assign too_big  = RW'(num_i) >= (RW'(den_i) << RATIO_LOG);
    assign trial    = root_q | (GAIN_W'(1) << step_q[$clog2(GAIN_W)-1:0]);
    assign trial_sq = QUO_W'(trial) * QUO_W'(trial);

    assign done_o = (state_q == RR_DONE);
    assign keep_o = keep_q;
    assign root_o = root_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RR_IDLE;
            rem_q   <= '0;
            dsh_q   <= '0;
            quo_q   <= '0;
            root_q  <= '0;
            step_q  <= '0;
            keep_q  <= 1'b0;
        end else begin
            case (state_q)
                RR_IDLE: begin
                    if (start_i) begin
                        keep_q <= 1'b0;
                        if (den_i == '0) begin
                            keep_q  <= 1'b1;
                            state_q <= RR_DONE;
                        end else if (too_big) begin
                            root_q  <= GAIN_MAX;
                            state_q <= RR_DONE;
                        end else begin
                            rem_q   <= RW'(num_i);
                            dsh_q   <= RW'(den_i) << (RATIO_LOG - 1);
                            quo_q   <= '0;
                            step_q  <= TW'(QUO_W - 1);
                            state_q <= RR_DIV;
                        end
                    end
                end
                // Restoring division, one quotient bit per cycle, MSB weight 2^(RATIO_LOG-1)
                RR_DIV: begin
                    if (rem_q >= dsh_q) begin
                        rem_q <= (rem_q - dsh_q) << 1;
                        quo_q <= {quo_q[QUO_W-2:0], 1'b1};
                    end else begin
                        rem_q <= rem_q << 1;
                        quo_q <= {quo_q[QUO_W-2:0], 1'b0};
                    end
                    if (step_q == '0) begin
                        root_q  <= '0;
                        step_q  <= TW'(GAIN_W - 1);
                        state_q <= RR_ROOT;
                    end else begin
                        step_q <= step_q - 1'b1;
                    end
                end
                // Bitwise integer square root, one result bit per cycle
                RR_ROOT: begin
                    if (trial_sq <= quo_q) begin
                        root_q <= trial;
                    end
                    if (step_q == '0) begin
                        state_q <= RR_DONE;
                    end else begin
                        step_q <= step_q - 1'b1;
                    end
                end
                default: begin
                    state_q <= RR_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/pge_gain_bank.sv
module pge_gain_bank import pge_pkg::*; #(
    parameter int NCH = 4,
    parameter int CW  = 2,
    parameter int SW  = 30
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        blk_end_i,
    input  logic [NCH-1:0][SW-1:0]      fin_i,
    output logic [NCH-1:0][GAIN_W-1:0]  gains_o,
    output logic                        commit_o
);

    gb_state_e                    state_q;
    logic [NCH-1:0][SW-1:0]       snap_q;
    logic [NCH-1:0][GAIN_W-1:0]   pend_q;
    logic [NCH-1:0][GAIN_W-1:0]   gain_q;
    logic [CW-1:0]                idx_q;
    logic                         rr_start;
    logic                         rr_done;
    logic                         rr_keep;
    logic [GAIN_W-1:0]            rr_root;

    assign rr_start = (state_q == GB_LAUNCH);
    assign commit_o = (state_q == GB_COMMIT);
    assign gains_o  = gain_q;

    pge_ratio_root #(
        .SW (SW)
    ) i_ratio_root (
        .clk     (clk),
        .rst     (rst),
        .start_i (rr_start),
        .num_i   (snap_q[0]),
        .den_i   (snap_q[idx_q]),
        .done_o  (rr_done),
        .keep_o  (rr_keep),
        .root_o  (rr_root)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GB_IDLE;
            snap_q  <= '0;
            idx_q   <= '0;
            for (int c = 0; c < NCH; c++) begin
                pend_q[c] <= GAIN_ONE;
                gain_q[c] <= GAIN_ONE;
            end
        end else begin
            case (state_q)
                GB_IDLE: begin
                    // A block that ends while the engine is busy is not taken
                    if (blk_end_i) begin
                        snap_q  <= fin_i;
                        idx_q   <= CW'(1);
                        state_q <= GB_LAUNCH;
                    end
                end
                GB_LAUNCH: begin
                    state_q <= GB_WAIT;
                end
                GB_WAIT: begin
                    if (rr_done) begin
                        pend_q[idx_q] <= rr_keep ? gain_q[idx_q] : rr_root;
                        if (idx_q == CW'(NCH - 1)) begin
                            state_q <= GB_COMMIT;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= GB_LAUNCH;
                        end
                    end
                end
                default: begin
                    for (int c = 0; c < NCH; c++) begin
                        gain_q[c] <= (c == 0) ? GAIN_ONE : pend_q[c];
                    end
                    state_q <= GB_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/pge_scaler.sv
module pge_scaler import pge_pkg::*; #(
    parameter int NCH = 4,
    parameter int DW  = 12,
    parameter int CW  = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        valid_i,
    input  logic signed [DW-1:0]        sample_i,
    input  logic [CW-1:0]               ch_i,
    input  logic [NCH-1:0][GAIN_W-1:0]  gains_i,
    output logic                        valid_o,
    output logic signed [DW-1:0]        sample_o
);

    localparam int PW = DW + GAIN_W + 1;
    localparam logic signed [PW-1:0] HI = $signed({{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}});
    localparam logic signed [PW-1:0] LO = $signed({{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}});

    logic [GAIN_W-1:0]      g;
    logic signed [PW-1:0]   xs;
    logic signed [PW-1:0]   gs;
    logic signed [PW-1:0]   prod;
    logic signed [PW-1:0]   rnd;
    logic signed [PW-1:0]   shf;
    logic signed [DW-1:0]   sat;

    assign g    = gains_i[ch_i];
    assign xs   = $signed({{(PW-DW){sample_i[DW-1]}}, sample_i});
    assign gs   = $signed({{(PW-GAIN_W){1'b0}}, g});
    assign prod = xs * gs;
    assign rnd  = prod + $signed(PW'(1) << (GAIN_FRAC - 1));
    assign shf  = rnd >>> GAIN_FRAC;

    always_comb begin
        if (shf > HI) begin
            sat = HI[DW-1:0];
        end else if (shf < LO) begin
            sat = LO[DW-1:0];
        end else begin
            sat = shf[DW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o  <= 1'b0;
            sample_o <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                sample_o <= sat;
            end
        end
    end

endmodule

// File: rtl/pwr_gain_equalizer.sv
module pwr_gain_equalizer import pge_pkg::*; #(
    parameter int NCH  = 4,
    parameter int DW   = 12,
    parameter int NLOG = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic signed [DW-1:0]      in_sample,
    output logic                      out_valid,
    output logic signed [DW-1:0]      out_sample,
    output logic [NCH*GAIN_W-1:0]     gain_flat
);

    localparam int CW = ch_bits(NCH);
    localparam int SW = 2 * DW + NLOG;

    logic [CW-1:0]               ch_w;
    logic                        blk_end_w;
    logic [NCH-1:0][SW-1:0]      fin_w;
    logic [NCH-1:0][GAIN_W-1:0]  gains_w;
    logic                        commit_w;

    pge_power_acc #(
        .NCH  (NCH),
        .DW   (DW),
        .NLOG (NLOG),
        .CW   (CW),
        .SW   (SW)
    ) i_power_acc (
        .clk         (clk),
        .rst         (rst),
        .in_valid_i  (in_valid),
        .in_sample_i (in_sample),
        .ch_o        (ch_w),
        .blk_end_o   (blk_end_w),
        .fin_o       (fin_w)
    );

    pge_gain_bank #(
        .NCH (NCH),
        .CW  (CW),
        .SW  (SW)
    ) i_gain_bank (
        .clk       (clk),
        .rst       (rst),
        .blk_end_i (blk_end_w),
        .fin_i     (fin_w),
        .gains_o   (gains_w),
        .commit_o  (commit_w)
    );

    pge_scaler #(
        .NCH (NCH),
        .DW  (DW),
        .CW  (CW)
    ) i_scaler (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (in_valid),
        .sample_i (in_sample),
        .ch_i     (ch_w),
        .gains_i  (gains_w),
        .valid_o  (out_valid),
        .sample_o (out_sample)
    );

    assign gain_flat = gains_w;

endmodule

// File: rtl/pge_checks.sv
module pge_checks import pge_pkg::*; #(
    parameter int NCH = 4,
    parameter int DW  = 12,
    parameter int CW  = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic signed [DW-1:0]   in_sample,
    input logic                   out_valid,
    input logic signed [DW-1:0]   out_sample,
    input logic [CW-1:0]          ch,
    input logic                   commit,
    input logic [NCH*GAIN_W-1:0]  gain_flat
);

    AST_REF_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ch == '0) |=> (out_sample == $past(in_sample))); // R1

    AST_CH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (ch == (($past(ch) == CW'(NCH - 1)) ? CW'(0) : CW'($past(ch) + 1'b1)))); // R2

    AST_CH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(ch)); // R2

    AST_OUT_VALID: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R3

    AST_OUT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R3

    AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(gain_flat)); // R8

endmodule

bind pwr_gain_equalizer pge_checks #(
    .NCH (NCH),
    .DW  (DW),
    .CW  (CW)
) i_pge_checks (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .ch         (ch_w),
    .commit     (commit_w),
    .gain_flat  (gain_flat)
);

// File: tb/test_pwr_gain_equalizer.sv
module test_pwr_gain_equalizer;

    localparam int NCH  = 4;
    localparam int DW   = 12;
    localparam int NLOG = 6;
    localparam int NS   = 1 << NLOG;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  in_valid = 1'b0;
    logic signed [DW-1:0]  in_sample = '0;
    logic                  out_valid;
    logic signed [DW-1:0]  out_sample;
    logic [NCH*16-1:0]     gain_flat;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0]     eg [NCH];
    longint          sums [NCH];
    int              bch = 0;
    int              bcnt = 0;
    int              chg = 0;
    logic [NCH*16-1:0] prevg = '0;

    always #4 clk = ~clk;

    pwr_gain_equalizer #(
        .NCH  (NCH),
        .DW   (DW),
        .NLOG (NLOG)
    ) i_pwr_gain_equalizer (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_sample (out_sample),
        .gain_flat  (gain_flat)
    );

    // Count cycles in which any gain field moved (R8)
    always @(negedge clk) begin
        if (gain_flat != prevg) chg++;
        prevg = gain_flat;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_gain(input longint s0, input longint sc,
                                             input logic [15:0] prev);
        longint q;
        longint r;
        if (sc == 0) return prev;
        if (s0 >= 16 * sc) return 16'hFFFF;
        q = (s0 <<< 28) / sc;
        r = 0;
        for (int b = 15; b >= 0; b--) begin
            longint t;
            t = r | (longint'(1) <<< b);
            if (t * t <= q) r = t;
        end
        return r[15:0];
    endfunction

    function automatic int exp_out(input int x, input logic [15:0] g);
        longint p;
        p = longint'(x) * longint'(g);
        p = (p + 8192) >>> 14;
        if (p > 2047) p = 2047;
        if (p < -2048) p = -2048;
        return int'(p);
    endfunction

    task automatic push(input int x);
        int e;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = DW'(x);
        e = exp_out(x, eg[bch]);
        @(posedge clk);
        #1;
        chk("R3 valid", longint'(out_valid), 1);
        chk((bch == 0) ? "R1" : "R3", longint'(out_sample), longint'(e));
        if (bcnt == 0) sums[bch] = longint'(x) * x;
        else sums[bch] += longint'(x) * x;
        if (bch == NCH - 1) begin
            bch = 0;
            bcnt = (bcnt == NS - 1) ? 0 : bcnt + 1;
        end else begin
            bch++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            @(posedge clk);
            #1;
            if (i == 0) chk("R3 idle", longint'(out_valid), 0);
        end
    endtask

    task automatic run_block(input int amp [NCH], input bit gaps, input string tag);
        logic [15:0] ng [NCH];
        int moved;
        chg = 0;
        for (int i = 0; i < NS * NCH; i++) begin
            int a;
            int x;
            a = amp[bch];
            x = (a == 0) ? 0 : int'($urandom_range(2 * a)) - a;
            push(x);
            if (gaps && ($urandom % 4 == 0)) idle(1 + int'($urandom % 3));
        end
        idle(400);
        moved = 0;
        for (int c = 0; c < NCH; c++) begin
            ng[c] = (c == 0) ? 16'h4000 : exp_gain(sums[0], sums[c], eg[c]);
            if (ng[c] != eg[c]) moved = 1;
            chk(tag, longint'(gain_flat[16*c +: 16]), longint'(ng[c]));
        end
        chk("R8 single update cycle", longint'(chg), longint'(moved));
        for (int c = 0; c < NCH; c++) eg[c] = ng[c];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int amp [NCH];
        void'($urandom(32'h1F2E3D4C));
        for (int c = 0; c < NCH; c++) begin
            eg[c] = 16'h4000;
            sums[c] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R4: reset values and field layout
        for (int c = 0; c < NCH; c++)
            chk("R4 reset gain", longint'(gain_flat[16*c +: 16]), 16'h4000);
        chk("R4 reset out_valid", longint'(out_valid), 0);

        // R5: plain block, continuous stream
        amp = '{1000, 800, 1200, 500};
        run_block(amp, 1'b0, "R5");
        // R9 and R2: new block with idle gaps, sums restart
        amp = '{900, 1500, 300, 2000};
        run_block(amp, 1'b1, "R9");
        // R7 silent channel 2, R6 weak channel 3
        amp = '{1800, 1000, 0, 40};
        run_block(amp, 1'b1, "R6 R7");
        // R3 saturation under large gains, then recomputed factors
        amp = '{2047, 2047, 2047, 2047};
        run_block(amp, 1'b0, "R5");
        // Directed extremes on each channel with the final factors
        push(-2048);
        push(-2048);
        push(2047);
        push(-2048);
        idle(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule